// File: doc/BRIEF.md
# Dual-Channel to Single-Port Pixel Merger with Double-Edge Output

This block takes two pixel words that arrive together on every input clock, the channel-A word carrying pixel n and the channel-B word carrying pixel n+1. It places them on one output port as an ordered pair of slots: slot 0 is emitted first and slot 1 second. The pair can be read two ways. In single-edge mode each slot is one period of an output clock that runs at twice the input rate. In double-edge mode the output clock stays at the input rate and each slot is captured on one of its two edges.

The output clock is described per input cycle as a four-quarter level pattern, `clk_lvl[0]` first. Pad behaviour is not built. A high-impedance output is shown as a cleared bit in a per-bit drive vector. A power pin and an output-enable pin select one of three states: everything floating, data driven low with the clock floating, or normal operation. A two-bit link-mode input says whether the receiver has one or two input links and one or two output ports. Merging happens only in the dual-in/single-out setting. In every other setting the port carries the channel-A word in both slots. All outputs are registered and change one clock after the inputs that set them.

Top module: `pix_merge_ddr`

## Requirements
- R1: While reset is held and on the first cycle after it, both slots, `data_drv`, `clk_lvl` and `clk_drv` are all zero.
- R2: With `link_mode` = 2'b01 (dual-in/single-out), powered and enabled, the cycle after an edge shows slot 0 = `pix_a` and slot 1 = `pix_b` as sampled at that edge.
- R3: In mode 2'b01 with `ddr_req` = 0 and `rise_sel` = 1, `clk_lvl` = 4'b1010. The output clock is low then high within each slot, so it runs at twice the input rate and rises in the middle of each slot.
- R4: In mode 2'b01 with `ddr_req` = 1 and `rise_sel` = 1, `clk_lvl` = 4'b0110. This is one output clock period per input cycle, rising inside slot 0 and falling inside slot 1. The slot data are the same as in R2.
- R5: Outside mode 2'b01, `ddr_req` has no effect. With `rise_sel` = 1, `clk_lvl` = 4'b1100, which is one period per cycle with its rising edge between the slots.
- R6: In modes 2'b11, 2'b10 and 2'b00, both slots carry `pix_a` and `pix_b` has no effect on the port.
- R7: With `pwr_on` = 0, regardless of `out_en`, the next cycle shows `data_drv`, both slots, `clk_lvl` and `clk_drv` all zero.
- R8: With `pwr_on` = 1 and `out_en` = 0, the next cycle shows `data_drv` all ones, both slots zero, `clk_drv` = 0 and `clk_lvl` = 0.
- R9: With `pwr_on` = 1 and `out_en` = 1, the next cycle shows `data_drv` all ones and `clk_drv` = 1, with exactly two high quarters in `clk_lvl`.
- R10: With `rise_sel` = 0, `clk_lvl` is the bitwise inverse of the R3, R4 or R5 pattern that applies, so the falling edge lands where the rising edge would have been.
- R11: On the first cycle after `pwr_on` rises, the port shows the new pair, with pixel n in slot 0 and pixel n+1 in slot 1. Nothing held from before power-down appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = operating, 0 = powered down |
| out_en | input | 1 | 1 = outputs active, 0 = data driven low |
| ddr_req | input | 1 | Double-edge output request (used in mode 2'b01 only) |
| rise_sel | input | 1 | 1 = data captured on rising clock edges, 0 = falling |
| link_mode | input | 2 | bit1: 1 = single input link; bit0: 1 = single output port |
| pix_a | input | W | Channel-A word, pixel n |
| pix_b | input | W | Channel-B word, pixel n+1 |
| slot0_q | output | W | First output slot |
| slot1_q | output | W | Second output slot |
| data_drv | output | W | Per-bit data drive enable (0 = floating) |
| clk_lvl | output | 4 | Output clock level per quarter cycle, bit 0 first |
| clk_drv | output | 1 | Output clock drive enable |

## Verification
The bench builds the block with a 12-bit word width. At that width the all-ones drive vector (12'hFFF) and the slot contents are easy to read. Distinct values on the two channels make any swap of slot order, or leak of channel B in a single-link mode, show up at once. The clock-pattern checks do not depend on the width, so all four link modes, both edge selections and both settings of the double-edge request are covered within a few dozen cycles. So are the three drive states and the return from power-down.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_LOW = 2'd1,
    DRV_ON  = 2'd2
  } drv_e;

  typedef struct packed {
    logic merge;
    logic ddr;
    drv_e drv;
  } ctl_t;

  localparam logic [1:0] MODE_DUAL_SINGLE = 2'b01;

  // quarter-cycle clock shape, bit 0 is the first quarter
  function automatic logic [3:0] clk_shape(input logic merge, input logic ddr,
                                           input logic rise);
    logic [3:0] p;
    if (merge && !ddr)      p = 4'b1010;
    else if (merge && ddr)  p = 4'b0110;
    else                    p = 4'b1100;
    return rise ? p : ~p;
  endfunction

  function automatic drv_e drv_state(input logic pwr, input logic oe);
    if (!pwr)     return DRV_OFF;
    else if (!oe) return DRV_LOW;
    else          return DRV_ON;
  endfunction

endpackage

// File: rtl/pm_mode_dec.sv
module pm_mode_dec
  import pm_pkg::*;
(
  input  logic [1:0] link_mode,
  input  logic       ddr_req,
  input  logic       pwr_on,
  input  logic       out_en,
  output ctl_t       ctl
);

  logic merge_w;

  assign merge_w   = (link_mode == MODE_DUAL_SINGLE);
  assign ctl.merge = merge_w;
  assign ctl.ddr   = merge_w & ddr_req;
  assign ctl.drv   = drv_state(pwr_on, out_en);

endmodule

// File: rtl/pm_slot_sel.sv
module pm_slot_sel
  import pm_pkg::*;
#(
  parameter int W = 30
) (
  input  ctl_t         ctl,
  input  logic [W-1:0] pix_a,
  input  logic [W-1:0] pix_b,
  output logic [W-1:0] nxt0,
  output logic [W-1:0] nxt1
);

  logic active_w;
  assign active_w = (ctl.drv == DRV_ON);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt0[i] = active_w & pix_a[i];
    assign nxt1[i] = active_w & (ctl.merge ? pix_b[i] : pix_a[i]);
  end

endmodule

// File: rtl/pm_out_reg.sv
module pm_out_reg
  import pm_pkg::*;
#(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl,
  input  logic         rise_sel,
  input  logic [W-1:0] nxt0,
  input  logic [W-1:0] nxt1,
  output logic [W-1:0] slot0_q,
  output logic [W-1:0] slot1_q,
  output logic [W-1:0] data_drv,
  output logic [3:0]   clk_lvl,
  output logic         clk_drv,
  output logic         live
);

  logic [3:0] shape_w;
  assign shape_w = clk_shape(ctl.merge, ctl.ddr, rise_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q  <= '0;
      slot1_q  <= '0;
      data_drv <= '0;
      clk_lvl  <= '0;
      clk_drv  <= 1'b0;
      live     <= 1'b0;
    end else begin
      slot0_q  <= nxt0;
      slot1_q  <= nxt1;
      data_drv <= {W{ctl.drv != DRV_OFF}};
      clk_lvl  <= (ctl.drv == DRV_ON) ? shape_w : 4'b0000;
      clk_drv  <= (ctl.drv == DRV_ON);
      live     <= 1'b1;
    end
  end

  // R7
  pd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ctl.drv) == DRV_OFF |->
      data_drv == '0 && !clk_drv && slot0_q == '0 && slot1_q == '0);

  // R8
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ctl.drv) == DRV_LOW |->
      (&data_drv) && clk_lvl == 4'b0000 && !clk_drv);

  // R9
  clk_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_drv |-> $countones(clk_lvl) == 2 && (&data_drv));

  // R10
  edge_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ctl.drv) == DRV_ON && !$past(rise_sel) && $past(ctl.merge)
      && !$past(ctl.ddr) |-> clk_lvl == 4'b0101);

endmodule

// File: rtl/pix_merge_ddr.sv
module pix_merge_ddr
  import pm_pkg::*;
#(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_on,
  input  logic         out_en,
  input  logic         ddr_req,
  input  logic         rise_sel,
  input  logic [1:0]   link_mode,
  input  logic [W-1:0] pix_a,
  input  logic [W-1:0] pix_b,
  output logic [W-1:0] slot0_q,
  output logic [W-1:0] slot1_q,
  output logic [W-1:0] data_drv,
  output logic [3:0]   clk_lvl,
  output logic         clk_drv
);

  ctl_t         ctl_w;
  logic [W-1:0] nxt0_w;
  logic [W-1:0] nxt1_w;
  logic         live_w;

  pm_mode_dec u_dec (
    .link_mode (link_mode),
    .ddr_req   (ddr_req),
    .pwr_on    (pwr_on),
    .out_en    (out_en),
    .ctl       (ctl_w)
  );

  pm_slot_sel #(.W(W)) u_sel (
    .ctl   (ctl_w),
    .pix_a (pix_a),
    .pix_b (pix_b),
    .nxt0  (nxt0_w),
    .nxt1  (nxt1_w)
  );

  pm_out_reg #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_w),
    .rise_sel (rise_sel),
    .nxt0     (nxt0_w),
    .nxt1     (nxt1_w),
    .slot0_q  (slot0_q),
    .slot1_q  (slot1_q),
    .data_drv (data_drv),
    .clk_lvl  (clk_lvl),
    .clk_drv  (clk_drv),
    .live     (live_w)
  );

  // R2
  merge_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_w && $past(link_mode) == 2'b01 && $past(pwr_on) && $past(out_en) |->
      slot0_q == $past(pix_a) && slot1_q == $past(pix_b));

  // R6
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_w && $past(link_mode) != 2'b01 && $past(pwr_on) && $past(out_en) |->
      slot0_q == $past(pix_a) && slot1_q == $past(pix_a));

  // R5
  ddr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_w && $past(link_mode) != 2'b01 && $past(pwr_on) && $past(out_en) |->
      (clk_lvl == 4'b1100 || clk_lvl == 4'b0011));

  // R4
  ddr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_w && $past(link_mode) == 2'b01 && $past(ddr_req) && $past(rise_sel)
      && $past(pwr_on) && $past(out_en) |-> clk_lvl == 4'b0110);

endmodule

// File: tb/sim_pix_merge_ddr.sv
`timescale 1ns/1ps
module sim_pix_merge_ddr;

  localparam int W = 12;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_on = 1'b0;
  logic         out_en = 1'b0;
  logic         ddr_req = 1'b0;
  logic         rise_sel = 1'b1;
  logic [1:0]   link_mode = 2'b01;
  logic [W-1:0] pix_a = '0;
  logic [W-1:0] pix_b = '0;
  logic [W-1:0] slot0_q, slot1_q, data_drv;
  logic [3:0]   clk_lvl;
  logic         clk_drv;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pix_merge_ddr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
    .ddr_req(ddr_req), .rise_sel(rise_sel), .link_mode(link_mode),
    .pix_a(pix_a), .pix_b(pix_b), .slot0_q(slot0_q), .slot1_q(slot1_q),
    .data_drv(data_drv), .clk_lvl(clk_lvl), .clk_drv(clk_drv)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic pw, input logic oe, input logic [1:0] md,
                       input logic dd, input logic rs,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    pwr_on = pw; out_en = oe; link_mode = md; ddr_req = dd; rise_sel = rs;
    pix_a = a; pix_b = b;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    chk("R1", "slot0", slot0_q, 0);
    chk("R1", "drv", data_drv, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "clk_lvl", clk_lvl, 0);
    chk("R1", "clk_drv", clk_drv, 0);
    chk("R1", "slot1", slot1_q, 0);
  endtask

  task automatic t_merge_single;
    apply(1, 1, 2'b01, 0, 1, 12'hA11, 12'hB22);
    chk("R2", "slot0", slot0_q, 12'hA11);
    chk("R2", "slot1", slot1_q, 12'hB22);
    chk("R3", "clk_lvl", clk_lvl, 4'b1010);
    chk("R9", "drv", data_drv, ONES);
    chk("R9", "clk_drv", clk_drv, 1);
    apply(1, 1, 2'b01, 0, 1, 12'h3C5, 12'h0F0);
    chk("R2", "slot0 b", slot0_q, 12'h3C5);
    chk("R2", "slot1 b", slot1_q, 12'h0F0);
  endtask

  task automatic t_ddr;
    apply(1, 1, 2'b01, 1, 1, 12'h123, 12'h456);
    chk("R4", "clk_lvl", clk_lvl, 4'b0110);
    chk("R4", "slot0", slot0_q, 12'h123);
    chk("R4", "slot1", slot1_q, 12'h456);
  endtask

  task automatic t_other_modes;
    logic [1:0] modes [3] = '{2'b11, 2'b10, 2'b00};
    for (int i = 0; i < 3; i++) begin
      apply(1, 1, modes[i], 1, 1, 12'h5A0 + 12'(i), 12'hE0E);
      chk("R5", "clk_lvl ddr set", clk_lvl, 4'b1100);
      chk("R6", "slot0", slot0_q, 12'h5A0 + 12'(i));
      chk("R6", "slot1 no chB", slot1_q, 12'h5A0 + 12'(i));
    end
  endtask

  task automatic t_edge_select;
    apply(1, 1, 2'b01, 0, 0, 12'h001, 12'h002);
    chk("R10", "merge fall", clk_lvl, 4'b0101);
    apply(1, 1, 2'b01, 1, 0, 12'h001, 12'h002);
    chk("R10", "ddr fall", clk_lvl, 4'b1001);
    apply(1, 1, 2'b11, 0, 0, 12'h001, 12'h002);
    chk("R10", "single fall", clk_lvl, 4'b0011);
  endtask

  task automatic t_oe_low;
    apply(1, 0, 2'b01, 0, 1, 12'h777, 12'h888);
    chk("R8", "drv", data_drv, ONES);
    chk("R8", "slot0", slot0_q, 0);
    chk("R8", "slot1", slot1_q, 0);
    chk("R8", "clk_drv", clk_drv, 0);
    chk("R8", "clk_lvl", clk_lvl, 0);
  endtask

  task automatic t_pdwn;
    apply(0, 1, 2'b01, 0, 1, 12'h999, 12'hAAA);
    chk("R7", "drv oe=1", data_drv, 0);
    chk("R7", "clk_drv", clk_drv, 0);
    chk("R7", "slot0", slot0_q, 0);
    apply(0, 0, 2'b01, 0, 1, 12'h999, 12'hAAA);
    chk("R7", "drv oe=0", data_drv, 0);
    chk("R7", "clk_lvl", clk_lvl, 0);
  endtask

  task automatic t_powerup;
    apply(1, 1, 2'b01, 0, 1, 12'hC01, 12'hC02);
    chk("R11", "first slot0", slot0_q, 12'hC01);
    chk("R11", "first slot1", slot1_q, 12'hC02);
    chk("R11", "clk_drv", clk_drv, 1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_merge_single();
    t_ddr();
    t_other_modes();
    t_edge_select();
    t_oe_low();
    t_pdwn();
    t_powerup();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule